// File: doc/BRIEF.md
# APB Configuration-Target Bridge

This block is an APB3 target that connects one fabric initiator to a small, fixed set of embedded configuration targets, such as transceiver lanes, transmit PLLs and clock-conditioning slices. The top bits of the APB address select a target. The bridge then drives that target's narrow control bus, which carries select, direction, byte strobes and word offset. Write data goes out on one bus shared by all targets. The bridge waits for the addressed target to acknowledge on bit 32 of its read-data bus.

If a target never acknowledges, a watchdog ends the transfer with an error response and pulses a timeout output. An access to a slot that is absent, locked or out of range also fails, with an error response. That failure sets a bus-error flag, which stays high until reset. A local register slot holds the per-target lock bits and the interrupt enables, and it shows the raw interrupt inputs. The interrupt output is the OR of the enabled target interrupts.

Software uses the local slot to lock targets that must not be touched and to choose which target interrupts reach the fabric. It then reads and writes target registers with ordinary APB transfers.

Top module: `cfg_apb_bridge`

## Requirements
- R1: After reset (presetn_i low on a rising edge, synchronous), pready_o, pslverr_o, ptimeout_o, buserr_o and irq_o are low, the lock register holds LOCK_INIT, the interrupt enables are 0, and tgt_rst_n_o is low while presetn_i is low.
- R2: The target index is paddr_i[28:26] and the word offset is paddr_i[6:2]. Only the addressed target sees its select bit. A target control bus packs select in bit 10, write in bit 9, byte strobes in bits 8:5 and offset in bits 4:0. Write data goes to the addressed target only.
- R3: A write updates only the bytes whose pstrb_i bit is high (bit n selects bits 8n+7:8n). No strobe is forwarded on a read.
- R4: During a target access pready_o stays low until bit 32 of that target's read-data bus is high. prdata_o then carries its bits 31:0 on reads, and is 0 on writes.
- R5: If the acknowledge has not come by zero-based access cycle TMO_CYC, the transfer completes in that cycle. It completes with pready_o and pslverr_o high, prdata_o zero and ptimeout_o high for that one cycle. An acknowledge in that same cycle completes normally.
- R6: An access to index 6, to an absent or locked target, or to a local offset above 2 completes in the first access cycle. It completes with pslverr_o high and prdata_o zero, and no target sees select or strobes.
- R7: buserr_o rises after an R6 error access (not after a timeout) and stays high until reset.
- R8: irq_o is the OR over targets of tgt_irq_i[i] AND interrupt-enable bit i.
- R9: Local slot index 7 holds three registers. Offset 0 is the lock mask (bit i locks target i). Offset 1 is the interrupt enable. Offset 2 is the read-only raw tgt_irq_i. Local accesses complete in the first access cycle without error, and only pstrb_i[0] enables a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | APB clock; also forwarded to targets |
| presetn_i | input | 1 | Active-low synchronous reset |
| paddr_i | input | 29 | APB address |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | High for write |
| pwdata_i | input | 32 | Write data |
| pstrb_i | input | 4 | Byte write strobes |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Transfer completion |
| pslverr_o | output | 1 | Error response |
| ptimeout_o | output | 1 | Watchdog expiry pulse |
| buserr_o | output | 1 | Sticky bus-error flag |
| irq_o | output | 1 | Aggregated enabled interrupt |
| tgt_clk_o | output | 1 | Target clock |
| tgt_rst_n_o | output | 1 | Active-low target reset |
| tgt_wdata_o | output | 32 | Shared target write data |
| tgt_ctrl_o | output | N_TGT*11 | Per-target control buses |
| tgt_rdata_i | input | N_TGT*33 | Per-target acknowledge and read data |
| tgt_irq_i | input | N_TGT | Per-target interrupt inputs |

## Verification
The bench uses a target whose latency equals the watchdog limit. A design that compared the counter off by one would time it out, or would let a never-answering target hang one cycle too long. Writes to a locked slot are followed by an unlock and a read-back. A bridge that forwarded strobes on errors would then show corrupted data. Partial and empty strobe patterns, and strobes other than bit 0 on the local slot, expose lane mixing. The sticky flag is watched on every cycle across error, timeout and good transfers, and it is then cleared by a reset partway through the run. This catches a flag that decays, that a timeout sets, or that survives reset.

// File: rtl/cfgb_pkg.sv
`timescale 1ns/1ps
package cfgb_pkg;
    localparam int ADDR_W     = 29;
    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    localparam int IDX_W      = 3;
    localparam int OFF_W      = 5;
    localparam int RD_W       = DATA_W + 1;
    localparam int SLOTS      = 1 << IDX_W;
    localparam int LOCAL_IDX  = SLOTS - 1;
    localparam int LOCAL_REGS = 3;

    typedef enum logic [1:0] {
        DST_TGT   = 2'd0,
        DST_LOCAL = 2'd1,
        DST_BAD   = 2'd2
    } dst_e;

    // control bus seen by one target: select, write, byte strobes, word offset
    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [STRB_W-1:0] strb;
        logic [OFF_W-1:0]  off;
    } tgt_ctrl_t;

    localparam int CTRL_W = $bits(tgt_ctrl_t);

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        for (int b = 0; b < STRB_W; b++) begin
            res[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/cfgb_decode.sv
`timescale 1ns/1ps
module cfgb_decode
    import cfgb_pkg::*;
#(
    parameter int N_TGT = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_TGT-1:0]  present,
    input  logic [N_TGT-1:0]  lock,
    output dst_e              dst,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);
    logic [SLOTS-1:0] usable;

    always_comb begin
        usable              = '0;
        usable[N_TGT-1:0]   = present & ~lock;
        idx                 = addr[ADDR_W-1 -: IDX_W];
        off                 = addr[OFF_W+1:2];
        if (idx == IDX_W'(LOCAL_IDX)) begin
            dst = (off < OFF_W'(LOCAL_REGS)) ? DST_LOCAL : DST_BAD;
        end else if (usable[idx]) begin
            dst = DST_TGT;
        end else begin
            dst = DST_BAD;
        end
    end
endmodule

// File: rtl/cfgb_watchdog.sv
`timescale 1ns/1ps
module cfgb_watchdog #(
    parameter int TMO_CYC = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(TMO_CYC));

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfgb_localregs.sv
`timescale 1ns/1ps
module cfgb_localregs
    import cfgb_pkg::*;
#(
    parameter int               N_TGT     = 6,
    parameter logic [N_TGT-1:0] LOCK_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    input  logic [N_TGT-1:0]  irq_raw,
    output logic [N_TGT-1:0]  lock_q,
    output logic [N_TGT-1:0]  ien_q,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= LOCK_INIT;
            ien_q  <= '0;
        end else if (wr_en) begin
            if (off == OFF_W'(0)) begin
                lock_q <= N_TGT'(lane_merge(DATA_W'(lock_q), wdata, strb));
            end
            if (off == OFF_W'(1)) begin
                ien_q <= N_TGT'(lane_merge(DATA_W'(ien_q), wdata, strb));
            end
        end
    end

    always_comb begin
        case (off)
            OFF_W'(0): rdata = DATA_W'(lock_q);
            OFF_W'(1): rdata = DATA_W'(ien_q);
            OFF_W'(2): rdata = DATA_W'(irq_raw);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_apb_bridge.sv
`timescale 1ns/1ps
module cfg_apb_bridge
    import cfgb_pkg::*;
#(
    parameter int               N_TGT        = 6,
    parameter logic [N_TGT-1:0] PRESENT_MASK = N_TGT'(6'b101111),
    parameter logic [N_TGT-1:0] LOCK_INIT    = '0,
    parameter int               TMO_CYC      = 255
) (
    input  logic                    pclk_i,
    input  logic                    presetn_i,
    input  logic [28:0]             paddr_i,
    input  logic                    psel_i,
    input  logic                    penable_i,
    input  logic                    pwrite_i,
    input  logic [31:0]             pwdata_i,
    input  logic [3:0]              pstrb_i,
    output logic [31:0]             prdata_o,
    output logic                    pready_o,
    output logic                    pslverr_o,
    output logic                    ptimeout_o,
    output logic                    buserr_o,
    output logic                    irq_o,
    output logic                    tgt_clk_o,
    output logic                    tgt_rst_n_o,
    output logic [31:0]             tgt_wdata_o,
    output logic [N_TGT*11-1:0]     tgt_ctrl_o,
    input  logic [N_TGT*33-1:0]     tgt_rdata_i,
    input  logic [N_TGT-1:0]        tgt_irq_i
);
    logic              rst;
    logic              acc;
    dst_e              dst;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    logic [N_TGT-1:0]  lock_q;
    logic [N_TGT-1:0]  ien_q;
    logic [DATA_W-1:0] loc_rdata;
    logic [SLOTS-1:0]  ack_slot;
    logic [DATA_W-1:0] dat_slot [SLOTS];
    logic              tgt_hit;
    logic              ack_sel;
    logic              expire;
    logic              buserr_q;

    assign rst         = ~presetn_i;
    assign acc         = psel_i && penable_i;
    assign tgt_clk_o   = pclk_i;
    assign tgt_rst_n_o = presetn_i;
    assign tgt_wdata_o = pwdata_i;

    cfgb_decode #(.N_TGT(N_TGT)) u_dec (
        .addr    (paddr_i),
        .present (PRESENT_MASK),
        .lock    (lock_q),
        .dst     (dst),
        .idx     (idx),
        .off     (off)
    );

    // unpack acknowledge and data per slot; unused slots read as idle
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < N_TGT) begin : g_used
            assign ack_slot[s] = tgt_rdata_i[s*RD_W + DATA_W];
            assign dat_slot[s] = tgt_rdata_i[s*RD_W +: DATA_W];
        end else begin : g_empty
            assign ack_slot[s] = 1'b0;
            assign dat_slot[s] = '0;
        end
    end

    assign tgt_hit = acc && (dst == DST_TGT);
    assign ack_sel = tgt_hit && ack_slot[idx];

    cfgb_watchdog #(.TMO_CYC(TMO_CYC)) u_wd (
        .clk    (pclk_i),
        .rst    (rst),
        .run    (tgt_hit && !ack_slot[idx]),
        .expire (expire)
    );

    cfgb_localregs #(.N_TGT(N_TGT), .LOCK_INIT(LOCK_INIT)) u_loc (
        .clk     (pclk_i),
        .rst     (rst),
        .wr_en   (acc && (dst == DST_LOCAL) && pwrite_i),
        .off     (off),
        .wdata   (pwdata_i),
        .strb    (pstrb_i),
        .irq_raw (tgt_irq_i),
        .lock_q  (lock_q),
        .ien_q   (ien_q),
        .rdata   (loc_rdata)
    );

    assign pready_o   = acc && ((dst != DST_TGT) || ack_sel || expire);
    assign pslverr_o  = acc && ((dst == DST_BAD) || expire);
    assign ptimeout_o = expire;

    always_comb begin
        prdata_o = '0;
        if (acc && !pwrite_i) begin
            if (dst == DST_LOCAL) begin
                prdata_o = loc_rdata;
            end else if (ack_sel) begin
                prdata_o = dat_slot[idx];
            end
        end
    end

    always_ff @(posedge pclk_i) begin
        if (rst) begin
            buserr_q <= 1'b0;
        end else if (acc && (dst == DST_BAD)) begin
            buserr_q <= 1'b1;
        end
    end
    assign buserr_o = buserr_q;

    for (genvar i = 0; i < N_TGT; i++) begin : g_ctrl
        tgt_ctrl_t c;
        always_comb begin
            c.sel  = tgt_hit && (idx == IDX_W'(i));
            c.wr   = c.sel && pwrite_i;
            c.strb = c.wr ? pstrb_i : '0;
            c.off  = c.sel ? off : '0;
        end
        assign tgt_ctrl_o[i*CTRL_W +: CTRL_W] = c;
    end

    assign irq_o = |(tgt_irq_i & ien_q);
endmodule

// File: rtl/cfgb_chk.sv
`timescale 1ns/1ps
module cfgb_chk
    import cfgb_pkg::*;
#(
    parameter int N_TGT = 6
) (
    input logic                clk,
    input logic                presetn,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic                pready,
    input logic                pslverr,
    input logic                ptimeout,
    input logic [31:0]         prdata,
    input logic                buserr,
    input logic [N_TGT*11-1:0] ctrl
);
    logic [N_TGT-1:0] sel_v;
    logic             any_strb;

    always_comb begin
        any_strb = 1'b0;
        for (int i = 0; i < N_TGT; i++) begin
            sel_v[i] = ctrl[i*CTRL_W + CTRL_W - 1];
            any_strb = any_strb || (ctrl[i*CTRL_W + OFF_W +: STRB_W] != '0);
        end
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!presetn)
        $onehot0(sel_v));
    // R3
    read_nostrb_chk: assert property (@(posedge clk) disable iff (!presetn)
        !pwrite |-> !any_strb);
    // R4
    idle_ready_chk: assert property (@(posedge clk) disable iff (!presetn)
        !(psel && penable) |-> !pready);
    // R5
    tmo_resp_chk: assert property (@(posedge clk) disable iff (!presetn)
        ptimeout |-> (pready && pslverr && prdata == 32'h0));
    // R5
    tmo_pulse_chk: assert property (@(posedge clk) disable iff (!presetn)
        ptimeout |=> !ptimeout);
    // R6
    err_nofwd_chk: assert property (@(posedge clk) disable iff (!presetn)
        (pslverr && !ptimeout) |-> (sel_v == '0 && !any_strb));
    // R7
    buserr_hold_chk: assert property (@(posedge clk) disable iff (!presetn)
        buserr |=> buserr);
    // R7
    buserr_cause_chk: assert property (@(posedge clk) disable iff (!presetn)
        $rose(buserr) |-> $past(pslverr && !ptimeout));
endmodule

bind cfg_apb_bridge cfgb_chk #(.N_TGT(N_TGT)) u_chk (
    .clk      (pclk_i),
    .presetn  (presetn_i),
    .psel     (psel_i),
    .penable  (penable_i),
    .pwrite   (pwrite_i),
    .pready   (pready_o),
    .pslverr  (pslverr_o),
    .ptimeout (ptimeout_o),
    .prdata   (prdata_o),
    .buserr   (buserr_o),
    .ctrl     (tgt_ctrl_o)
);

// File: tb/tb_tgt_stub.sv
`timescale 1ns/1ps
module tb_tgt_stub #(
    parameter int LAT = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [10:0] ctrl,
    input  logic [31:0] wdata,
    output logic [32:0] rdata
);
    logic [31:0] mem [32];
    int          cnt;
    logic        ready;

    assign ready = ctrl[10] && (cnt >= LAT);
    assign rdata = ready ? {1'b1, mem[ctrl[4:0]]} : 33'h0;

    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl[10]) begin
            cnt <= 0;
        end else if (cnt < LAT) begin
            cnt <= cnt + 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 32; w++) mem[w] <= 32'h0;
        end else if (ready && ctrl[9]) begin
            for (int b = 0; b < 4; b++) begin
                if (ctrl[5+b]) mem[ctrl[4:0]][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end
endmodule

// File: tb/tb_cfg_apb_bridge.sv
`timescale 1ns/1ps
module tb_cfg_apb_bridge;
    localparam int N   = 6;
    localparam int TMO = 255;
    localparam logic [N-1:0] PRES = 6'b101111;

    logic          clk = 1'b0;
    logic          presetn;
    logic [28:0]   paddr;
    logic          psel, penable, pwrite;
    logic [31:0]   pwdata;
    logic [3:0]    pstrb;
    logic [31:0]   prdata;
    logic          pready, pslverr, ptimeout, buserr, irq;
    logic          tclk, trst_n;
    logic [31:0]   twdata;
    logic [N*11-1:0] tctrl;
    logic [N*33-1:0] trdata;
    logic [N-1:0]  tirq;

    int nchk = 0;
    int nerr = 0;
    bit mon_on = 0;
    bit finished = 0;

    logic [31:0] m_mem [N][32];
    logic [N-1:0] m_lock, m_ien;
    bit m_buserr;

    always #4 clk = ~clk;

    function automatic int lat_of(int i);
        case (i)
            0: return 0;
            1: return 3;
            2: return 1;
            3: return TMO;
            4: return 0;
            default: return 1000000;
        endcase
    endfunction

    cfg_apb_bridge dut (
        .pclk_i(clk), .presetn_i(presetn), .paddr_i(paddr), .psel_i(psel),
        .penable_i(penable), .pwrite_i(pwrite), .pwdata_i(pwdata), .pstrb_i(pstrb),
        .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
        .ptimeout_o(ptimeout), .buserr_o(buserr), .irq_o(irq),
        .tgt_clk_o(tclk), .tgt_rst_n_o(trst_n), .tgt_wdata_o(twdata),
        .tgt_ctrl_o(tctrl), .tgt_rdata_i(trdata), .tgt_irq_i(tirq)
    );

    for (genvar g = 0; g < N; g++) begin : g_stub
        tb_tgt_stub #(.LAT(lat_of(g))) u_stub (
            .clk(tclk), .rst_n(trst_n), .ctrl(tctrl[g*11 +: 11]),
            .wdata(twdata), .rdata(trdata[g*33 +: 33])
        );
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < N; t++)
            for (int w = 0; w < 32; w++) m_mem[t][w] = 32'h0;
        m_lock = '0;
        m_ien = '0;
        m_buserr = 0;
    endtask

    function automatic logic [31:0] bytes_upd(logic [31:0] o, logic [31:0] n, logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // kind: 0 target, 1 local, 2 error
    task automatic xfer(input logic [2:0] idx, input logic [4:0] off, input bit wr,
                        input logic [31:0] wd, input logic [3:0] st, input string tag);
        int kind, e_wait, waits, tpulses;
        bit e_err, e_tmo, got_err, done;
        logic [31:0] e_rd, got_rd;
        if (idx == 3'd7) kind = (off < 5'd3) ? 1 : 2;
        else if (int'(idx) >= N) kind = 2;
        else if (!PRES[idx] || m_lock[idx]) kind = 2;
        else kind = 0;
        e_wait = 0; e_err = 0; e_tmo = 0; e_rd = 32'h0;
        if (kind == 2) e_err = 1;
        else if (kind == 1) begin
            if (!wr) e_rd = (off == 0) ? 32'(m_lock) : (off == 1) ? 32'(m_ien) : 32'(tirq);
        end else begin
            if (lat_of(int'(idx)) > TMO) begin
                e_wait = TMO; e_err = 1; e_tmo = 1;
            end else begin
                e_wait = lat_of(int'(idx));
                if (!wr) e_rd = m_mem[idx][off];
            end
        end
        @(negedge clk);
        paddr = {idx, 19'b0, off, 2'b00};
        pwrite = wr; pwdata = wd; pstrb = st; psel = 1; penable = 0;
        @(negedge clk);
        penable = 1;
        waits = 0; tpulses = 0; done = 0;
        got_rd = 0; got_err = 0;
        while (!done) begin
            #2;
            if (ptimeout) tpulses++;
            if (pready) begin
                got_rd = prdata; got_err = pslverr; done = 1;
            end else begin
                @(negedge clk);
                waits++;
            end
        end
        chk(waits == e_wait, tag, "wait cycles", 32'(waits), 32'(e_wait));
        chk(got_err == e_err, tag, "pslverr", 32'(got_err), 32'(e_err));
        chk(got_rd == e_rd, tag, "prdata", got_rd, e_rd);
        chk(tpulses == int'(e_tmo), tag, "timeout pulses", 32'(tpulses), 32'(e_tmo));
        @(posedge clk);
        if (kind == 2) m_buserr = 1;
        if (wr && kind == 1) begin
            if (off == 0) m_lock = N'(bytes_upd(32'(m_lock), wd, st));
            if (off == 1) m_ien  = N'(bytes_upd(32'(m_ien), wd, st));
        end
        if (wr && kind == 0 && !e_tmo) m_mem[idx][off] = bytes_upd(m_mem[idx][off], wd, st);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    // per-cycle comparison against the reference model
    always begin
        @(negedge clk);
        #3;
        if (mon_on && !finished) begin
            chk(irq == |(tirq & m_ien), "R8", "irq_o", 32'(irq), 32'(|(tirq & m_ien)));
            chk(buserr == m_buserr, "R7", "buserr_o", 32'(buserr), 32'(m_buserr));
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog run did not finish actual=hang expected=done");
        summary();
    end

    initial begin
        presetn = 0; psel = 0; penable = 0; pwrite = 0;
        paddr = '0; pwdata = '0; pstrb = '0; tirq = '1;
        model_reset();
        repeat (3) @(negedge clk);
        #2 chk(trst_n == 1'b0, "R1", "target reset in reset", 32'(trst_n), 32'h0);
        @(negedge clk);
        presetn = 1;
        repeat (2) @(negedge clk);
        #2;
        chk(pready == 0, "R1", "pready idle", 32'(pready), 0);
        chk(pslverr == 0, "R1", "pslverr idle", 32'(pslverr), 0);
        chk(ptimeout == 0, "R1", "ptimeout idle", 32'(ptimeout), 0);
        chk(buserr == 0, "R1", "buserr after reset", 32'(buserr), 0);
        chk(irq == 0, "R1", "irq with enables clear", 32'(irq), 0);
        mon_on = 1;
        xfer(3'd7, 5'd0, 0, 0, 0, "R1");
        xfer(3'd7, 5'd1, 0, 0, 0, "R1");

        // R2 R4 data path and wait states
        xfer(3'd0, 5'd3, 1, 32'hA5A5_1234, 4'hF, "R2");
        xfer(3'd1, 5'd3, 1, 32'h1111_2222, 4'hF, "R4");
        xfer(3'd2, 5'd3, 1, 32'h0000_0033, 4'hF, "R2");
        xfer(3'd0, 5'd3, 0, 0, 0, "R2");
        xfer(3'd1, 5'd3, 0, 0, 0, "R4");
        xfer(3'd2, 5'd3, 0, 0, 0, "R2");
        xfer(3'd1, 5'd17, 1, 32'hCAFE_F00D, 4'hF, "R4");
        xfer(3'd1, 5'd17, 0, 0, 0, "R4");

        // R3 byte strobes
        xfer(3'd0, 5'd3, 1, 32'hFFFF_FFFF, 4'b0101, "R3");
        xfer(3'd0, 5'd3, 0, 0, 0, "R3");
        xfer(3'd0, 5'd3, 1, 32'h0000_0000, 4'b0000, "R3");
        xfer(3'd0, 5'd3, 0, 0, 0, "R3");
        xfer(3'd2, 5'd3, 1, 32'h9900_0000, 4'b1000, "R3");
        xfer(3'd2, 5'd3, 0, 0, 0, "R3");

        // R5 acknowledge exactly at the limit, then no acknowledge at all
        xfer(3'd3, 5'd9, 1, 32'h0BAD_BEEF, 4'hF, "R5");
        xfer(3'd3, 5'd9, 0, 0, 0, "R5");
        xfer(3'd5, 5'd1, 0, 0, 0, "R5");
        xfer(3'd5, 5'd1, 1, 32'h1234_5678, 4'hF, "R5");

        // R8 R9 interrupts and local registers
        xfer(3'd7, 5'd1, 1, 32'h0000_0005, 4'b0001, "R9");
        xfer(3'd7, 5'd1, 0, 0, 0, "R9");
        @(negedge clk); tirq = 6'b000010;
        #2 chk(irq == 0, "R8", "masked source", 32'(irq), 0);
        xfer(3'd7, 5'd2, 0, 0, 0, "R9");
        @(negedge clk); tirq = 6'b000100;
        #2 chk(irq == 1, "R8", "enabled source", 32'(irq), 1);
        xfer(3'd7, 5'd2, 0, 0, 0, "R9");
        xfer(3'd7, 5'd2, 1, 32'hFFFF_FFFF, 4'hF, "R9");
        xfer(3'd7, 5'd2, 0, 0, 0, "R9");
        xfer(3'd7, 5'd0, 1, 32'h0000_00FF, 4'b1110, "R9");
        xfer(3'd7, 5'd0, 0, 0, 0, "R9");

        // R6 R7 lock, absent, out of range; strobes must not leak
        xfer(3'd7, 5'd0, 1, 32'h0000_0004, 4'b0001, "R6");
        xfer(3'd2, 5'd3, 1, 32'hDEAD_DEAD, 4'hF, "R6");
        #2 chk(buserr == 1, "R7", "flag after locked access", 32'(buserr), 1);
        xfer(3'd7, 5'd0, 1, 32'h0000_0000, 4'b0001, "R6");
        xfer(3'd2, 5'd3, 0, 0, 0, "R6");
        xfer(3'd4, 5'd0, 0, 0, 0, "R6");
        xfer(3'd6, 5'd0, 1, 32'h5555_5555, 4'hF, "R6");
        xfer(3'd7, 5'd5, 0, 0, 0, "R6");
        xfer(3'd0, 5'd3, 0, 0, 0, "R7");
        xfer(3'd5, 5'd0, 0, 0, 0, "R7");
        #2 chk(buserr == 1, "R7", "flag held after good traffic", 32'(buserr), 1);

        // R7 reset clears the flag
        mon_on = 0;
        @(negedge clk); presetn = 0;
        repeat (2) @(negedge clk);
        presetn = 1;
        model_reset();
        @(negedge clk);
        #2 chk(buserr == 0, "R7", "flag cleared by reset", 32'(buserr), 0);
        mon_on = 1;
        xfer(3'd0, 5'd3, 0, 0, 0, "R1");
        xfer(3'd7, 5'd1, 0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule